// File: doc/BRIEF.md
# Audio Soft Mute Ramp

This block is a per-sample gain stage for a stereo stream of 24-bit two's complement audio. On request it fades the stream gradually to silence, and on release it fades the stream back to full level. Each step of the fade is taken on a sample-valid strobe, which arrives once per stereo frame. The left and right samples share one attenuation counter, so both channels always carry the same gain.

The mute request has two possible sources. One is a direct pin, used for parallel control. The other is a bit held by a control register elsewhere, used for serial control. A select input chooses which source drives the fade.

The attenuation count runs from 0 (unity gain) to 1024 (silence). Each sample is multiplied by (1024 - count)/1024 and rounded toward zero. The result is registered and presented one clock after its strobe. A flag reports when the count sits at full silence.

Top module: `smute_ramp_top`

## Requirements
- R1: While reset (rst_n low on a clock edge) is applied, and after it is released, the attenuation count is 0. Both sample outputs are 0, out_valid is 0 and muted is 0.
- R2: On each smp_valid strobe with the effective request high, the count rises by one, up to 1024. Each output equals the input times (1024 - count)/1024, where count is the value after that strobe's step.
- R3: After 1024 strobes with the request high, muted is 1 and every output is exactly 0 for any input. Further strobes keep the count at 1024.
- R4: On each strobe with the effective request low, the count falls by one, down to 0. At count 0 the output equals the input bit for bit.
- R5: When the request changes partway through a fade, the count reverses from its present value on the next strobe. It does not restart from either end.
- R6: The scaled result is rounded toward zero, so a negative product is never rounded down. Full-scale inputs 0x7FFFFF and 0x800000 never overflow.
- R7: The left and right outputs of a strobe are scaled by the same gain.
- R8: With src_sel = 0 the request comes from mute_pin and mute_bit is ignored. With src_sel = 1 the request comes from mute_bit and mute_pin is ignored.
- R9: Without a strobe, the count and both sample outputs hold their values.
- R10: out_valid is high exactly in the cycle after a clock edge that saw smp_valid high. The outputs of that strobe are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mute_pin | input | 1 | Mute request from the parallel-control pin |
| mute_bit | input | 1 | Mute request from the control register bit |
| src_sel | input | 1 | Request source: 0 = pin, 1 = register bit |
| smp_valid | input | 1 | Stereo sample strobe; one step of the ramp |
| left_in | input | 24 | Left sample, two's complement |
| right_in | input | 24 | Right sample, two's complement |
| left_out | output | 24 | Attenuated left sample |
| right_out | output | 24 | Attenuated right sample |
| out_valid | output | 1 | Outputs hold the result of the previous strobe |
| muted | output | 1 | Attenuation count is at full silence |

## Verification
A change of the mute request and a sample strobe can land on the same clock edge. In that case the step direction must already follow the new request, which reverses a fade in progress. The bench provokes this by changing the pin or the register bit in the same cycle as a strobe, both mid-fade and at the saturated ends. It compares every scaled output against a bench model that takes the request value seen at that strobe. A second coincidence arises when the final fade step and the muted flag both change on one edge. That strobe must already produce zero output, and the bench checks it together with the flag.

// File: rtl/smute_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the soft mute ramp.
// Assumes: nothing beyond the standard language.
package smute_pkg;

    // Which source drives the mute request.
    typedef enum logic {
        SRC_PIN = 1'b0,
        SRC_REG = 1'b1
    } mute_src_e;

    // Number of audio channels carried by the stage.
    localparam int NUM_CH = 2;

endpackage

// File: rtl/smute_req_sel.sv
`timescale 1ns/1ps
// Module: smute_req_sel
// Picks the effective mute request from the pin or the register bit.
// Assumes: both inputs are already synchronous to clk.
module smute_req_sel
    import smute_pkg::*;
(
    input  logic      mute_pin,
    input  logic      mute_bit,
    input  mute_src_e src_sel,
    output logic      mute_req
);

    // Route the selected source to the ramp counter.
    always_comb begin
        unique case (src_sel)
            SRC_REG: mute_req = mute_bit;
            default: mute_req = mute_pin;
        endcase
    end

endmodule

// File: rtl/smute_ramp_ctr.sv
`timescale 1ns/1ps
// Module: smute_ramp_ctr
// Up/down attenuation counter, saturating at 0 and at the ramp length.
// It steps once per strobe and exposes the gain numerator for the
// count that results from the current step.
// Assumes: step is a single-cycle strobe per stereo frame.
module smute_ramp_ctr #(
    parameter int RAMP_LOG2 = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step,
    input  logic                 mute_req,
    output logic [RAMP_LOG2:0]   gain_nxt,
    output logic                 full_mute
);

    localparam int CNT_W = RAMP_LOG2 + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(1) << RAMP_LOG2;

    logic [CNT_W-1:0] att_q;
    logic [CNT_W-1:0] att_d;

    // Next count: move one step toward the requested end, saturating.
    always_comb begin
        att_d = att_q;
        if (step) begin
            if (mute_req && (att_q != CNT_MAX))
                att_d = att_q + CNT_W'(1);
            else if (!mute_req && (att_q != '0))
                att_d = att_q - CNT_W'(1);
        end
    end

    // Gain numerator that applies to the sample of this strobe.
    always_comb gain_nxt = CNT_MAX - att_d;

    // Silence flag taken from the stored count.
    always_comb full_mute = (att_q == CNT_MAX);

    // Count register with synchronous reset to unity gain.
    always_ff @(posedge clk) begin
        if (!rst_n) att_q <= '0;
        else        att_q <= att_d;
    end

    // R2: a fade-down strobe below the ceiling adds one step.
    a_r2_fade_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mute_req && (att_q != CNT_MAX)) |=> (att_q == $past(att_q) + CNT_W'(1)));

    // R5: a fade-up strobe above zero removes one step from wherever it is.
    a_r5_rise_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !mute_req && (att_q != '0)) |=> (att_q == $past(att_q) - CNT_W'(1)));

    // R3: the count never passes the silence point.
    a_r3_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (att_q <= CNT_MAX));

    // R9: without a strobe the count holds.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(att_q));

endmodule

// File: rtl/smute_gain_mul.sv
`timescale 1ns/1ps
// Module: smute_gain_mul
// Multiplies one sample by gain/2^RAMP_LOG2, rounds toward zero and
// registers the result on the strobe.
// Assumes: gain never exceeds 2^RAMP_LOG2.
module smute_gain_mul #(
    parameter int SMP_W     = 24,
    parameter int RAMP_LOG2 = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [RAMP_LOG2:0]   gain,
    input  logic [SMP_W-1:0]     smp_in,
    output logic [SMP_W-1:0]     smp_out
);

    localparam int CNT_W  = RAMP_LOG2 + 1;
    localparam int PROD_W = SMP_W + CNT_W + 1;
    localparam logic [CNT_W-1:0] UNITY = CNT_W'(1) << RAMP_LOG2;

    logic signed [PROD_W-1:0] s_ext;
    logic signed [PROD_W-1:0] g_ext;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] biased;
    logic        [SMP_W-1:0]  smp_d;
    logic        [SMP_W-1:0]  smp_q;

    // Product with a bias on negative values so the shift truncates toward zero.
    always_comb begin
        s_ext  = PROD_W'($signed(smp_in));
        g_ext  = $signed(PROD_W'({1'b0, gain}));
        prod   = s_ext * g_ext;
        biased = prod + (prod[PROD_W-1] ? PROD_W'((1 << RAMP_LOG2) - 1) : '0);
        smp_d  = biased[RAMP_LOG2 +: SMP_W];
    end

    // Output register, loaded once per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  smp_q <= '0;
        else if (en) smp_q <= smp_d;
    end

    assign smp_out = smp_q;

    // R6: the scaled value always fits the sample width.
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> ((biased[PROD_W-1:RAMP_LOG2+SMP_W-1] == '0) ||
                (biased[PROD_W-1:RAMP_LOG2+SMP_W-1] == '1)));

    // R6: rounding toward zero never flips the sign of the sample.
    a_r6_toward_zero: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ((smp_out == '0) || (smp_out[SMP_W-1] == $past(smp_in[SMP_W-1]))));

    // R4: unity gain passes the sample unchanged.
    a_r4_unity: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (gain == UNITY)) |=> (smp_out == $past(smp_in)));

    // R3: zero gain yields exact silence.
    a_r3_zero_gain: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (gain == '0)) |=> (smp_out == '0));

    // R9: without a strobe the output holds.
    a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(smp_out));

endmodule

// File: rtl/smute_ramp_top.sv
`timescale 1ns/1ps
// Module: smute_ramp_top
// Stereo soft mute: a shared attenuation ramp drives one gain stage
// per channel. The outputs of a strobe appear one clock after it.
// Assumes: smp_valid is high for one cycle per stereo frame.
module smute_ramp_top
    import smute_pkg::*;
#(
    parameter int SMP_W     = 24,
    parameter int RAMP_LOG2 = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mute_pin,
    input  logic              mute_bit,
    input  logic              src_sel,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  left_in,
    input  logic [SMP_W-1:0]  right_in,
    output logic [SMP_W-1:0]  left_out,
    output logic [SMP_W-1:0]  right_out,
    output logic              out_valid,
    output logic              muted
);

    localparam int CNT_W = RAMP_LOG2 + 1;

    logic                          mute_req;
    logic [CNT_W-1:0]              gain_nxt;
    logic [NUM_CH-1:0][SMP_W-1:0]  ch_in;
    logic [NUM_CH-1:0][SMP_W-1:0]  ch_out;
    logic                          vld_q;

    smute_req_sel u_sel (
        .mute_pin (mute_pin),
        .mute_bit (mute_bit),
        .src_sel  (mute_src_e'(src_sel)),
        .mute_req (mute_req)
    );

    smute_ramp_ctr #(.RAMP_LOG2(RAMP_LOG2)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (smp_valid),
        .mute_req  (mute_req),
        .gain_nxt  (gain_nxt),
        .full_mute (muted)
    );

    // Pack the channels so each gain stage is instantiated from one loop.
    always_comb begin
        ch_in[0] = left_in;
        ch_in[1] = right_in;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        smute_gain_mul #(.SMP_W(SMP_W), .RAMP_LOG2(RAMP_LOG2)) u_mul (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (smp_valid),
            .gain    (gain_nxt),
            .smp_in  (ch_in[g]),
            .smp_out (ch_out[g])
        );
    end

    assign left_out  = ch_out[0];
    assign right_out = ch_out[1];

    // Output strobe, one clock behind the input strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= smp_valid;
    end

    assign out_valid = vld_q;

    // R10: every strobe produces a valid output on the next cycle.
    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> out_valid);

    // R10: no strobe means no valid output on the next cycle.
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !out_valid);

    // R3: when the silence flag is up, a fresh output is zero on both channels.
    a_r3_silent_out: assert property (@(posedge clk) disable iff (!rst_n)
        (muted && out_valid) |-> ((left_out == '0) && (right_out == '0)));

    // R7: equal inputs on both channels give equal outputs.
    a_r7_shared_gain: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && (left_in == right_in)) |=> (left_out == right_out));

endmodule

// File: tb/smute_ramp_top_tb_top.sv
`timescale 1ns/1ps
module smute_ramp_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mute_pin, mute_bit, src_sel, smp_valid;
    logic [23:0] left_in, right_in;
    logic [23:0] left_out, right_out;
    logic        out_valid, muted;

    int n_chk = 0;
    int n_err = 0;
    int model_att = 0;
    bit done = 0;
    int unsigned seed_val = 32'h5EED_0042;

    always #10 clk = ~clk;

    smute_ramp_top dut_i (
        .clk(clk), .rst_n(rst_n), .mute_pin(mute_pin), .mute_bit(mute_bit),
        .src_sel(src_sel), .smp_valid(smp_valid), .left_in(left_in),
        .right_in(right_in), .left_out(left_out), .right_out(right_out),
        .out_valid(out_valid), .muted(muted)
    );

    function automatic longint sext24(logic [23:0] v);
        longint t = longint'(v);
        if (v[23]) t = t - (longint'(1) << 24);
        return t;
    endfunction

    // Expected scaled sample: x * (1024 - att) / 1024, truncated toward zero.
    function automatic longint scale(longint x, int att);
        longint p = x * longint'(1024 - att);
        if (p < 0) return -((-p) / 1024);
        return p / 1024;
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issue one strobe at the current negedge, step the model, check outputs.
    task automatic strobe(logic [23:0] l, logic [23:0] r, string req);
        bit eff;
        left_in = l; right_in = r; smp_valid = 1'b1;
        eff = src_sel ? mute_bit : mute_pin;
        @(posedge clk);
        if (eff && model_att < 1024) model_att++;
        else if (!eff && model_att > 0) model_att--;
        @(negedge clk);
        smp_valid = 1'b0;
        check(out_valid == 1'b1, "R10", longint'(out_valid), 1);
        check(sext24(left_out) == scale(sext24(l), model_att), req,
              sext24(left_out), scale(sext24(l), model_att));
        check(sext24(right_out) == scale(sext24(r), model_att), "R7",
              sext24(right_out), scale(sext24(r), model_att));
        check(muted == (model_att == 1024), "R3", longint'(muted),
              longint'(model_att == 1024));
    endtask

    function automatic logic [23:0] rnd();
        return 24'($urandom());
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [23:0] hold_l, hold_r;
        void'($urandom(seed_val));
        rst_n = 1'b0; mute_pin = 1'b0; mute_bit = 1'b0; src_sel = 1'b0;
        smp_valid = 1'b0; left_in = '0; right_in = '0;
        repeat (3) @(negedge clk);
        // R1: state during and just after reset.
        check(out_valid == 0 && muted == 0, "R1", longint'({out_valid, muted}), 0);
        rst_n = 1'b1;
        check(left_out == 0 && right_out == 0, "R1", sext24(left_out), 0);
        // Smp strobe during reset must not move anything.
        rst_n = 1'b0; smp_valid = 1'b1; mute_pin = 1'b1; left_in = 24'h123456;
        @(negedge clk);
        rst_n = 1'b1; smp_valid = 1'b0; mute_pin = 1'b0;
        check(muted == 0 && left_out == 0, "R1", sext24(left_out), 0);

        // R4 / R6: unity pass-through, full-scale corners.
        strobe(24'h7FFFFF, 24'h800000, "R6");
        strobe(24'h000000, 24'hFFFFFF, "R4");
        for (int i = 0; i < 16; i++) strobe(rnd(), rnd(), "R4");

        // R2: fade down, request raised in the same cycle as the strobe.
        mute_pin = 1'b1;
        for (int i = 0; i < 1024; i++) begin
            if (i % 97 == 5) strobe(24'h800000, 24'h7FFFFF, "R6");
            else if (i % 61 == 3) strobe(24'hFFFFFF, 24'h000001, "R6");
            else strobe(rnd(), rnd(), "R2");
        end
        check(model_att == 1024 && muted == 1, "R3", longint'(muted), 1);
        for (int i = 0; i < 6; i++) strobe(24'h7FFFFF, 24'h800000, "R3");

        // R9: idle cycles hold outputs and give no valid.
        hold_l = left_out; hold_r = right_out;
        mute_pin = 1'b0;
        repeat (5) begin
            @(negedge clk);
            check(out_valid == 0, "R10", longint'(out_valid), 0);
            check(left_out == hold_l && right_out == hold_r, "R9",
                  sext24(left_out), sext24(hold_l));
        end
        check(muted == 1, "R9", longint'(muted), 1);

        // R4: full fade back up.
        for (int i = 0; i < 1024; i++) strobe(rnd(), rnd(), "R4");
        check(model_att == 0, "R4", model_att, 0);

        // R5: reverse partway through a fade-down, then partway up.
        mute_pin = 1'b1;
        for (int i = 0; i < 300; i++) strobe(rnd(), rnd(), "R2");
        mute_pin = 1'b0;
        for (int i = 0; i < 200; i++) strobe(rnd(), rnd(), "R5");
        mute_pin = 1'b1;
        for (int i = 0; i < 50; i++) strobe(rnd(), rnd(), "R5");
        check(model_att == 150, "R5", model_att, 150);

        // R8: register source selected, pin ignored.
        src_sel = 1'b1; mute_pin = 1'b1; mute_bit = 1'b0;
        for (int i = 0; i < 40; i++) strobe(rnd(), rnd(), "R8");
        mute_pin = 1'b0; mute_bit = 1'b1;
        for (int i = 0; i < 40; i++) strobe(rnd(), rnd(), "R8");
        // Pin source selected, register bit ignored.
        src_sel = 1'b0; mute_bit = 1'b1; mute_pin = 1'b0;
        for (int i = 0; i < 200; i++) strobe(rnd(), rnd(), "R8");
        check(model_att == 0 && muted == 0, "R8", model_att, 0);
        strobe(24'h7FFFFF, 24'h800000, "R4");

        done = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule